// File: doc/BRIEF.md
# Concurrent Predictive Grammar Recognizer

This block recognises sentences of one fixed context-free grammar. It does not step through a program. Every pending prediction of every rule alternative lives in its own flip-flop, and all of them advance together. The grammar has six alternatives:

- S→Ac
- S→aD
- A→a
- A→ab
- D→bd
- D→d

The terminals are a, b, c and d. The language is therefore exactly the four strings ac, abc, abd and ad.

Terminals arrive one per valid/ready handshake. Each arrival takes two cycles:

- **Read step.** The symbol is tested against every pending prediction of that terminal. The matches are latched.
- **Settle step.** The latched matches fire the next predictions and the completions. Unmatched predictions die.

An end-of-string strobe closes the string. One cycle later the block raises `done` together with an accept flag and a 6-bit mask. The mask names the rule alternatives that the complete parse confirmed. Partial analyses that died along the way stay out of the mask.

Top module: `pgr_recognizer`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every prediction, completion and result, and re-arms the opening predictions. The opening predictions are both S alternatives, each expecting a. After reset `done`, `accept` and `alt_mask` read 0 and `sym_ready` reads 1.
- R2: Terminals are coded on `sym` as a=0, b=1, c=2, d=3. A symbol is taken on a clock edge where `sym_valid` and `sym_ready` are both high and `str_end` is low.
- R3: While the string is still a valid prefix, a taken symbol drops `sym_ready` for exactly one settle cycle. `sym_ready` is high again on the following cycle.
- R4: At end of string, `accept` is 1 exactly for the strings ac, abc, abd and ad.
- R5: `alt_mask` uses these bit positions:

  | Bit | Alternative |
  |-----|-------------|
  | 0 | S→Ac |
  | 1 | S→aD |
  | 2 | A→a |
  | 3 | A→ab |
  | 4 | D→bd |
  | 5 | D→d |

  An accepted string reports the following masks:

  | String | Mask |
  |--------|------|
  | ac | 6'b000101 |
  | abc | 6'b001001 |
  | abd | 6'b010010 |
  | ad | 6'b100010 |

  For abd, both A bits are 0.
- R6: A symbol that matches no pending prediction sets a sticky reject. From then on, symbols are still taken with `sym_ready` held high, but they change nothing. The end strobe then reports `accept`=0.
- R7: The following cases are rejected at end of string:
  - the empty string;
  - a proper prefix of a sentence, such as a or ab;
  - a sentence followed by any further symbol.
- R8: `str_end` is honoured only while `sym_ready` is high. `done` rises on the next cycle. `done`, `accept` and `alt_mask` then hold until reset, and `sym_ready` stays low while `done` is high.
- R9: Whenever `done` is high and `accept` is 0, `alt_mask` is 0.
- R10: If `str_end` and `sym_valid` are high in the same read cycle, the end strobe wins. The symbol is not consumed, and the result is that of the string without it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_valid | input | 1 | A terminal is offered on `sym` |
| sym_ready | output | 1 | Block is in its read step and will take a symbol or end strobe |
| sym | input | 2 | Terminal code (a=0, b=1, c=2, d=3) |
| str_end | input | 1 | End-of-string strobe |
| done | output | 1 | Result valid, held until reset |
| accept | output | 1 | String belongs to the language |
| alt_mask | output | 6 | Rule alternatives confirmed by the complete parse |

## Verification
The checker assumes three things about the inputs:

- `rst` is driven from time zero.
- `sym_valid`, `sym` and `str_end` change only away from the active edge.
- A string is closed only once.

The stimulus keeps to these assumptions. It drives on the falling edge and, before every offer, waits for `sym_ready`. Each string is closed with a single strobe, and the block is reset before the next string. Random strings draw each terminal from the full 2-bit code, with a bias towards a leading a so that valid prefixes come up often. Directed strings cover each sentence, the prefixes, trailing junk, the empty string and a symbol offered together with the end strobe.

// File: rtl/pgr_pkg.sv
package pgr_pkg;

    localparam int SYM_W  = 2;
    localparam int N_CELL = 9;   // one pending-prediction cell per terminal use site and origin
    localparam int N_FIN  = 4;   // one completion cell per full derivation path of S
    localparam int N_ALT  = 6;

    typedef logic [SYM_W-1:0]  sym_t;
    typedef logic [N_CELL-1:0] cell_vec_t;
    typedef logic [N_FIN-1:0]  fin_vec_t;
    typedef logic [N_ALT-1:0]  alt_mask_t;

    localparam sym_t T_A = 2'd0;
    localparam sym_t T_B = 2'd1;
    localparam sym_t T_C = 2'd2;
    localparam sym_t T_D = 2'd3;

    typedef enum logic [1:0] {PH_READ, PH_SETTLE, PH_DONE} phase_e;

    // prediction cells
    localparam int C_A_IN_A1    = 0;  // a of A->a
    localparam int C_A_IN_A2    = 1;  // a of A->ab
    localparam int C_A_IN_S2    = 2;  // a of S->aD
    localparam int C_B_IN_A2    = 3;  // b of A->ab
    localparam int C_B_IN_D1    = 4;  // b of D->bd
    localparam int C_C_AFTER_A1 = 5;  // c of S->Ac, A done via A->a
    localparam int C_C_AFTER_A2 = 6;  // c of S->Ac, A done via A->ab
    localparam int C_D_IN_D1    = 7;  // d of D->bd
    localparam int C_D_IN_D2    = 8;  // d of D->d

    // completion cells
    localparam int F_S1A1 = 0;
    localparam int F_S1A2 = 1;
    localparam int F_S2D1 = 2;
    localparam int F_S2D2 = 3;

    // confirmation mask bits
    localparam int ALT_S1 = 0;
    localparam int ALT_S2 = 1;
    localparam int ALT_A1 = 2;
    localparam int ALT_A2 = 3;
    localparam int ALT_D1 = 4;
    localparam int ALT_D2 = 5;

    typedef struct packed {
        logic      accept;
        alt_mask_t mask;
    } verdict_t;

    function automatic sym_t cell_symbol(int idx);
        case (idx)
            C_A_IN_A1, C_A_IN_A2, C_A_IN_S2: return T_A;
            C_B_IN_A2, C_B_IN_D1:            return T_B;
            C_C_AFTER_A1, C_C_AFTER_A2:      return T_C;
            default:                         return T_D;
        endcase
    endfunction

    // both S alternatives predicted at once
    function automatic cell_vec_t start_cells();
        cell_vec_t v;
        v = '0;
        v[C_A_IN_A1] = 1'b1;
        v[C_A_IN_A2] = 1'b1;
        v[C_A_IN_S2] = 1'b1;
        return v;
    endfunction

    // set terms: a matched cell fires its successors
    function automatic cell_vec_t advance_cells(cell_vec_t hit);
        cell_vec_t v;
        v = '0;
        v[C_C_AFTER_A1] = hit[C_A_IN_A1];
        v[C_B_IN_A2]    = hit[C_A_IN_A2];
        v[C_B_IN_D1]    = hit[C_A_IN_S2];
        v[C_D_IN_D2]    = hit[C_A_IN_S2];
        v[C_C_AFTER_A2] = hit[C_B_IN_A2];
        v[C_D_IN_D1]    = hit[C_B_IN_D1];
        return v;
    endfunction

    function automatic fin_vec_t finish_cells(cell_vec_t hit);
        fin_vec_t f;
        f = '0;
        f[F_S1A1] = hit[C_C_AFTER_A1];
        f[F_S1A2] = hit[C_C_AFTER_A2];
        f[F_S2D1] = hit[C_D_IN_D1];
        f[F_S2D2] = hit[C_D_IN_D2];
        return f;
    endfunction

    function automatic alt_mask_t fin_to_mask(fin_vec_t f);
        alt_mask_t m;
        m = '0;
        m[ALT_S1] = f[F_S1A1] | f[F_S1A2];
        m[ALT_S2] = f[F_S2D1] | f[F_S2D2];
        m[ALT_A1] = f[F_S1A1];
        m[ALT_A2] = f[F_S1A2];
        m[ALT_D1] = f[F_S2D1];
        m[ALT_D2] = f[F_S2D2];
        return m;
    endfunction

endpackage

// File: rtl/pgr_term_test.sv
module pgr_term_test
    import pgr_pkg::*;
#(
    parameter int NC = N_CELL
) (
    input  logic [NC-1:0] pend,
    input  sym_t          sym,
    output logic [NC-1:0] hit
);

    // AND term per cell: pending and the arriving terminal equals its terminal
    for (genvar g = 0; g < NC; g++) begin : g_cell
        assign hit[g] = pend[g] & (sym == cell_symbol(g));
    end

endmodule

// File: rtl/pgr_pred_store.sv
module pgr_pred_store
    import pgr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      capture,
    input  logic      settle,
    input  cell_vec_t hit_in,
    output cell_vec_t pend,
    output fin_vec_t  fin,
    output logic      hit_none
);

    cell_vec_t pend_q;
    cell_vec_t hit_q;
    fin_vec_t  fin_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= start_cells();
            hit_q  <= '0;
            fin_q  <= '0;
        end else begin
            if (capture) begin
                hit_q <= hit_in;
            end
            if (settle) begin
                pend_q <= advance_cells(hit_q);
                fin_q  <= finish_cells(hit_q);
            end
        end
    end

    assign pend     = pend_q;
    assign fin      = fin_q;
    assign hit_none = (hit_q == '0);

endmodule

// File: rtl/pgr_result.sv
module pgr_result
    import pgr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      finish,
    input  fin_vec_t  fin,
    input  logic      rejected,
    output logic      done,
    output verdict_t  verdict
);

    logic     done_q;
    verdict_t verdict_q;
    verdict_t verdict_d;

    always_comb begin
        verdict_d.accept = (|fin) & ~rejected;
        verdict_d.mask   = rejected ? '0 : fin_to_mask(fin);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q    <= 1'b0;
            verdict_q <= '0;
        end else if (finish && !done_q) begin
            done_q    <= 1'b1;
            verdict_q <= verdict_d;
        end
    end

    assign done    = done_q;
    assign verdict = verdict_q;

endmodule

// File: rtl/pgr_recognizer.sv
module pgr_recognizer
    import pgr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sym_valid,
    output logic             sym_ready,
    input  logic [SYM_W-1:0] sym,
    input  logic             str_end,
    output logic             done,
    output logic             accept,
    output logic [N_ALT-1:0] alt_mask
);

    phase_e    phase_q;
    phase_e    phase_d;
    logic      take_sym;
    logic      take_end;
    logic      settle;
    logic      reject_q;
    logic      hit_none;
    cell_vec_t pend;
    cell_vec_t hit;
    fin_vec_t  fin;
    verdict_t  verdict;

    always_comb begin
        phase_d  = phase_q;
        take_sym = 1'b0;
        take_end = 1'b0;
        settle   = 1'b0;
        unique case (phase_q)
            PH_READ: begin
                if (str_end) begin
                    take_end = 1'b1;
                    phase_d  = PH_DONE;
                end else if (sym_valid && !reject_q) begin
                    take_sym = 1'b1;
                    phase_d  = PH_SETTLE;
                end
            end
            PH_SETTLE: begin
                settle  = 1'b1;
                phase_d = PH_READ;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_READ;
            reject_q <= 1'b0;
        end else begin
            phase_q <= phase_d;
            if (settle && hit_none) begin
                reject_q <= 1'b1;
            end
        end
    end

    pgr_term_test u_test (
        .pend (pend),
        .sym  (sym),
        .hit  (hit)
    );

    pgr_pred_store u_store (
        .clk      (clk),
        .rst      (rst),
        .capture  (take_sym),
        .settle   (settle),
        .hit_in   (hit),
        .pend     (pend),
        .fin      (fin),
        .hit_none (hit_none)
    );

    pgr_result u_result (
        .clk      (clk),
        .rst      (rst),
        .finish   (take_end),
        .fin      (fin),
        .rejected (reject_q),
        .done     (done),
        .verdict  (verdict)
    );

    assign sym_ready = (phase_q == PH_READ);
    assign accept    = verdict.accept;
    assign alt_mask  = verdict.mask;

endmodule

// File: rtl/pgr_recognizer_chk.sv
module pgr_recognizer_chk (
    input logic       clk,
    input logic       rst,
    input logic       sym_valid,
    input logic       sym_ready,
    input logic       str_end,
    input logic       done,
    input logic       accept,
    input logic [5:0] alt_mask,
    input logic       rej
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!done && !accept && alt_mask == '0 && sym_ready)); // R1

    AST_SETTLE_GAP: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && sym_ready && !str_end && !rej) |=> !sym_ready); // R3

    AST_SETTLE_ONE: assert property (@(posedge clk) disable iff (rst)
        (!sym_ready && !done) |=> sym_ready); // R3

    AST_REJECT_STICKY: assert property (@(posedge clk) disable iff (rst)
        rej |=> rej); // R6

    AST_REJECT_NO_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (rej && done) |-> !accept); // R6

    AST_MASK_SHAPE: assert property (@(posedge clk) disable iff (rst)
        (done && accept) |-> ($countones(alt_mask) == 2)); // R5

    AST_END_TO_DONE: assert property (@(posedge clk) disable iff (rst)
        (str_end && sym_ready) |=> done); // R8

    AST_NO_EARLY_DONE: assert property (@(posedge clk) disable iff (rst)
        (!done && !(str_end && sym_ready)) |=> !done); // R8

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        done |=> (done && $stable(accept) && $stable(alt_mask))); // R8

    AST_DONE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        done |-> !sym_ready); // R8

    AST_REJECT_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (done && !accept) |-> (alt_mask == '0)); // R9

endmodule

bind pgr_recognizer pgr_recognizer_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .sym_valid (sym_valid),
    .sym_ready (sym_ready),
    .str_end   (str_end),
    .done      (done),
    .accept    (accept),
    .alt_mask  (alt_mask),
    .rej       (reject_q)
);

// File: tb/pgr_recognizer_tb_top.sv
`timescale 1ns/1ps
module pgr_recognizer_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sym_valid = 1'b0;
    logic       sym_ready;
    logic [1:0] sym = 2'd0;
    logic       str_end = 1'b0;
    logic       done;
    logic       accept;
    logic [5:0] alt_mask;

    int total = 0;
    int bad   = 0;
    logic [1:0] str_buf [6];

    always #2.5 clk = ~clk;

    pgr_recognizer dut_i (
        .clk       (clk),
        .rst       (rst),
        .sym_valid (sym_valid),
        .sym_ready (sym_ready),
        .sym       (sym),
        .str_end   (str_end),
        .done      (done),
        .accept    (accept),
        .alt_mask  (alt_mask)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // true when s[0..n-1] begins some sentence of the language
    function automatic bit prefix_ok(input logic [1:0] s [6], input int n);
        if (n == 0) return 1'b1;
        if (s[0] != 2'd0) return 1'b0;
        if (n == 1) return 1'b1;
        if (n == 2) return s[1] != 2'd0;
        if (n == 3) return (s[1] == 2'd1) && (s[2] == 2'd2 || s[2] == 2'd3);
        return 1'b0;
    endfunction

    // expected confirmation mask, bits S1,S2,A1,A2,D1,D2 from bit 0 upwards
    function automatic logic [5:0] exp_mask(input logic [1:0] s [6], input int n);
        if (n == 2 && s[0] == 2'd0 && s[1] == 2'd2) return 6'b000101;
        if (n == 2 && s[0] == 2'd0 && s[1] == 2'd3) return 6'b100010;
        if (n == 3 && s[0] == 2'd0 && s[1] == 2'd1 && s[2] == 2'd2) return 6'b001001;
        if (n == 3 && s[0] == 2'd0 && s[1] == 2'd1 && s[2] == 2'd3) return 6'b010010;
        return 6'b000000;
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        sym_valid = 1'b0;
        str_end = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check(done == 1'b0 && accept == 1'b0, "R1 done/accept after reset", {done, accept}, 0);
        check(alt_mask == 6'd0, "R1 mask after reset", alt_mask, 0);
        check(sym_ready == 1'b1, "R1 ready after reset", sym_ready, 1);
    endtask

    task automatic send_sym(input logic [1:0] s, input bit gap);
        while (!sym_ready) @(negedge clk);
        sym_valid = 1'b1;
        sym = s;
        @(negedge clk);
        sym_valid = 1'b0;
        if (gap)
            check(sym_ready == 1'b0, "R3 ready low in settle", sym_ready, 0);
        else
            check(sym_ready == 1'b1, "R6 rejected symbol taken and ignored", sym_ready, 1);
    endtask

    task automatic send_end(input logic [5:0] em, input bit with_sym);
        while (!sym_ready) @(negedge clk);
        str_end = 1'b1;
        if (with_sym) begin
            sym_valid = 1'b1;
            sym = 2'($urandom_range(0, 3));
        end
        @(negedge clk);
        str_end = 1'b0;
        sym_valid = 1'b0;
        check(done == 1'b1, "R8 done after end strobe", done, 1);
        check(accept == (em != 6'd0), with_sym ? "R10 accept with symbol at end" : "R4 accept",
              accept, int'(em != 6'd0));
        check(alt_mask == em, (em != 6'd0) ? "R5 mask" : "R9 mask on reject", alt_mask, em);
        check(sym_ready == 1'b0, "R8 ready low while done", sym_ready, 0);
        sym_valid = 1'b1;
        @(negedge clk);
        sym_valid = 1'b0;
        check(done && accept == (em != 6'd0) && alt_mask == em, "R8 result held",
              {done, accept, alt_mask}, {1'b1, em != 6'd0, em});
    endtask

    task automatic run_string(input int n, input bit end_with_sym);
        do_reset();
        for (int k = 0; k < n; k++) begin
            send_sym(str_buf[k], prefix_ok(str_buf, k));
        end
        send_end(exp_mask(str_buf, n), end_with_sym);
    endtask

    task automatic load(input logic [1:0] a0, input logic [1:0] a1, input logic [1:0] a2,
                        input logic [1:0] a3, input logic [1:0] a4);
        str_buf[0] = a0; str_buf[1] = a1; str_buf[2] = a2;
        str_buf[3] = a3; str_buf[4] = a4; str_buf[5] = 2'd0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R8 actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1d2c3b4a));
        // R2 R4 R5: each sentence, codes a=0 b=1 c=2 d=3
        load(0, 2, 0, 0, 0); run_string(2, 1'b0);   // ac
        load(0, 1, 2, 0, 0); run_string(3, 1'b0);   // abc
        load(0, 1, 3, 0, 0); run_string(3, 1'b0);   // abd, A bits clear
        load(0, 3, 0, 0, 0); run_string(2, 1'b0);   // ad
        // R7: empty, prefixes, trailing symbol
        load(0, 0, 0, 0, 0); run_string(0, 1'b0);
        run_string(1, 1'b0);                         // a
        load(0, 1, 0, 0, 0); run_string(2, 1'b0);   // ab
        load(0, 2, 2, 0, 0); run_string(3, 1'b0);   // acc
        load(0, 1, 3, 3, 0); run_string(4, 1'b0);   // abdd
        // R6: early mismatch then symbols that would otherwise form a sentence
        load(1, 0, 3, 0, 0); run_string(3, 1'b0);
        load(0, 0, 0, 1, 3); run_string(5, 1'b0);
        // R10: symbol offered together with the end strobe
        load(0, 3, 0, 0, 0); run_string(2, 1'b1);
        load(0, 1, 0, 0, 0); run_string(2, 1'b1);
        // random strings
        for (int i = 0; i < 400; i++) begin
            int n;
            n = $urandom_range(0, 5);
            for (int k = 0; k < 6; k++) begin
                if (k == 0 && $urandom_range(0, 3) != 0)
                    str_buf[k] = 2'd0;
                else
                    str_buf[k] = 2'($urandom_range(0, 3));
            end
            run_string(n, ($urandom_range(0, 7) == 0));
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule